// File: doc/BRIEF.md
# RC oscillation ratio converter

This block is the digital counting core of a resistance-to-digital converter. An external RC oscillator shares one capacitor and can run either through a reference resistor or through a sensor resistor. The block enables one element at a time through its drive outputs. It counts the oscillation edges that come back and returns a 16-bit number proportional to the ratio of the sensor-mode frequency to the reference-mode frequency.

A conversion has two phases. In the reference phase, a time-base counter is loaded with a preset. It advances on each reference oscillation rising edge until it wraps past all ones, so it covers 2^16 − preset reference cycles. The number of system clock cycles this takes is recorded. In the sensor phase, the sensor element is enabled for exactly that many system clock cycles, and the sensor oscillation rising edges are counted. The count is the result. Two channels share the logic by time division: a start command latches the channel select, and only that channel's pins are driven until the conversion ends or is stopped. A monitor output shows the synchronised oscillation of the running channel. Completion raises a one-cycle interrupt request when the interrupt enable is set.

Top module: `rcr_conv`

## Requirements
- R1: After reset every drive output, busy, irq, mon_out, ovf and result are 0.
- R2: A start sampled while idle (with stop low) latches ch_sel and preset. From the next cycle busy is 1, and ref_drv and cap_drv have only the bit of the latched channel set. sns_drv is 0.
- R3: The reference phase ends on the (2^16 − preset)-th rising edge of the selected oscillation input, with a preset of 0xFFFF meaning one edge. Including the two-flop synchroniser and edge detector, it lasts (N−1)·P + P/2 + 3 clock cycles for an input of period P clocks that starts low when the drive turns on. ref_drv then falls and sns_drv of the same channel rises.
- R4: The sensor phase lasts exactly as many clock cycles as the reference phase. The result is the number of sensor-input rising edges detected during it, which is proportional to the sensor/reference frequency ratio.
- R5: At completion, result is updated, and busy and all drive outputs go to 0. irq is high for exactly one cycle if irq_en was 1 at start, and stays low if it was 0.
- R6: A sensor count that would pass all ones saturates at all ones and sets ovf. ovf stays set until the next accepted start, which clears it from the following cycle.
- R7: A start while busy is ignored: the channel, the preset and the phase timing of the running conversion are unchanged.
- R8: A stop while busy returns the block to idle on the next cycle with all drives 0. It raises no irq and leaves result at its previous value.
- R9: While busy, mon_out equals the selected oscillation input delayed by the two synchroniser stages. While idle, mon_out is 0.
- R10: At most one of all ref_drv and sns_drv bits is high at any time. Activity on the unselected channel's oscillation input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | NCH | Oscillation input, one per channel, asynchronous |
| start | input | 1 | Start pulse, accepted only when idle |
| stop | input | 1 | Abort command, priority over start and completion |
| ch_sel | input | CH_W | Channel to convert, latched at start |
| preset | input | TB_W | Time-base preset, latched at start |
| irq_en | input | 1 | Interrupt enable, latched at start |
| ref_drv | output | NCH | Reference resistor drive enable per channel |
| sns_drv | output | NCH | Sensor resistor drive enable per channel |
| cap_drv | output | NCH | Reference capacitor enable for the running channel |
| mon_out | output | 1 | Synchronised oscillation of the running channel |
| busy | output | 1 | Conversion in progress |
| result | output | CNT_W | Last completed sensor count |
| ovf | output | 1 | Sticky sensor count saturation flag |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
A time-base or phase-timer fault changes the length of the ref_drv and sns_drv windows. That shows in the first conversion as a reference window that is off from (N−1)·P + P/2 + 3, or as a sensor window that differs from it. A fault in edge detection or in the channel mux moves result away from the edge count expected for the two periods, or lets noise on the idle channel change it. This is visible when the conversion completes. Control faults show within one cycle of the command on busy, the drive outputs and irq: a stop that still interrupts, a start while busy that switches channel, or ovf that is not cleared by a start.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REF  = 2'd1,
        ST_SNS  = 2'd2
    } rcr_state_e;

    typedef struct packed {
        logic run;
        logic ref_on;
        logic sns_on;
    } rcr_drive_t;

    function automatic rcr_drive_t drive_of(rcr_state_e s);
        rcr_drive_t d;
        d = '0;
        case (s)
            ST_REF:  begin d.run = 1'b1; d.ref_on = 1'b1; end
            ST_SNS:  begin d.run = 1'b1; d.sns_on = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rcr_sync.sv
module rcr_sync #(
    parameter int NCH    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] osc_in,
    output logic [NCH-1:0] sync_q,
    output logic [NCH-1:0] rise
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [STAGES-1:0] sh;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[STAGES-2:0], osc_in[c]};
                prev <= sh[STAGES-1];
            end
        end

        assign sync_q[c] = sh[STAGES-1];
        assign rise[c]   = sh[STAGES-1] & ~prev;
    end

endmodule

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
    import rcr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CH_W   = 1,
    parameter int TB_W   = 16,
    parameter int TIME_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            stop,
    input  logic [CH_W-1:0] ch_sel,
    input  logic [TB_W-1:0] preset,
    input  logic            rise_sel,
    output rcr_state_e      state,
    output logic [CH_W-1:0] ch_q,
    output logic            start_acc,
    output logic            done
);

    logic [TB_W-1:0]   tb_q;
    logic [TIME_W-1:0] t_cnt;
    logic [TIME_W-1:0] t_ref;
    logic [TIME_W-1:0] t_inc;

    assign t_inc     = (t_cnt == '1) ? t_cnt : t_cnt + TIME_W'(1);
    assign start_acc = (state == ST_IDLE) && start && !stop;
    assign done      = (state == ST_SNS) && !stop && (t_inc == t_ref);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ch_q  <= '0;
            tb_q  <= '0;
            t_cnt <= '0;
            t_ref <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_acc) begin
                        state <= ST_REF;
                        ch_q  <= (int'(ch_sel) < NCH) ? ch_sel : '0;
                        tb_q  <= preset;
                        t_cnt <= '0;
                    end
                end
                ST_REF: begin
                    if (stop) begin
                        state <= ST_IDLE;
                    end else if (rise_sel && (tb_q == '1)) begin
                        state <= ST_SNS;
                        t_ref <= t_inc;
                        t_cnt <= '0;
                    end else begin
                        if (rise_sel) begin
                            tb_q <= tb_q + TB_W'(1);
                        end
                        t_cnt <= t_inc;
                    end
                end
                ST_SNS: begin
                    if (stop || done) begin
                        state <= ST_IDLE;
                    end else begin
                        t_cnt <= t_inc;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rcr_count.sv
module rcr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    input  logic             done,
    input  logic             irq_arm,
    output logic [CNT_W-1:0] result,
    output logic             ovf,
    output logic             irq
);

    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_next;
    logic             sat_hit;

    assign sat_hit  = inc && (acc == '1);
    assign acc_next = (inc && !sat_hit) ? acc + CNT_W'(1) : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
            ovf    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= done && irq_arm;
            if (clear) begin
                acc <= '0;
                ovf <= 1'b0;
            end else begin
                acc <= acc_next;
                if (sat_hit) begin
                    ovf <= 1'b1;
                end
            end
            if (done) begin
                result <= acc_next;
            end
        end
    end

endmodule

// File: rtl/rcr_conv.sv
module rcr_conv
    import rcr_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CNT_W       = 16,
    parameter int TB_W        = 16,
    parameter int TIME_W      = 24,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   osc_in,
    input  logic             start,
    input  logic             stop,
    input  logic [CH_W-1:0]  ch_sel,
    input  logic [TB_W-1:0]  preset,
    input  logic             irq_en,
    output logic [NCH-1:0]   ref_drv,
    output logic [NCH-1:0]   sns_drv,
    output logic [NCH-1:0]   cap_drv,
    output logic             mon_out,
    output logic             busy,
    output logic [CNT_W-1:0] result,
    output logic             ovf,
    output logic             irq
);

    logic [NCH-1:0]  sync_q;
    logic [NCH-1:0]  rise;
    logic            rise_sel;
    rcr_state_e      state;
    logic [CH_W-1:0] ch_q;
    logic            start_acc;
    logic            done;
    logic            irq_arm;
    rcr_drive_t      drv;
    logic [NCH-1:0]  ch_hot;

    rcr_sync #(
        .NCH    (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .osc_in (osc_in),
        .sync_q (sync_q),
        .rise   (rise)
    );

    assign rise_sel = rise[ch_q];

    rcr_ctrl #(
        .NCH    (NCH),
        .CH_W   (CH_W),
        .TB_W   (TB_W),
        .TIME_W (TIME_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .ch_sel    (ch_sel),
        .preset    (preset),
        .rise_sel  (rise_sel),
        .state     (state),
        .ch_q      (ch_q),
        .start_acc (start_acc),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_arm <= 1'b0;
        end else if (start_acc) begin
            irq_arm <= irq_en;
        end
    end

    assign drv    = drive_of(state);
    assign ch_hot = NCH'(1) << ch_q;

    rcr_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_acc),
        .inc     (drv.sns_on && rise_sel),
        .done    (done),
        .irq_arm (irq_arm),
        .result  (result),
        .ovf     (ovf),
        .irq     (irq)
    );

    assign ref_drv = drv.ref_on ? ch_hot : '0;
    assign sns_drv = drv.sns_on ? ch_hot : '0;
    assign cap_drv = drv.run    ? ch_hot : '0;
    assign busy    = drv.run;
    assign mon_out = drv.run && sync_q[ch_q];

endmodule

// File: rtl/rcr_conv_chk.sv
module rcr_conv_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           stop,
    input logic [NCH-1:0] ref_drv,
    input logic [NCH-1:0] sns_drv,
    input logic [NCH-1:0] cap_drv,
    input logic           mon_out,
    input logic           busy,
    input logic           ovf,
    input logic           irq
);

    a_r10_single_pin: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_drv, sns_drv}));

    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !stop) |=>
            (busy && $onehot(ref_drv) && (sns_drv == '0) && (cap_drv == ref_drv)));

    a_r3_phase_order: assert property (@(posedge clk) disable iff (rst)
        ($past(|ref_drv) && !(|ref_drv)) |-> ((|sns_drv) || $past(stop)));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r5_irq_after_run: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!busy && $past(|sns_drv)));

    a_r6_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(start && !busy && !stop)) |=> ovf);

    a_r7_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cap_drv == $past(cap_drv)));

    a_r8_stop_abort: assert property (@(posedge clk) disable iff (rst)
        (busy && stop) |=>
            (!busy && !irq && (ref_drv == '0) && (sns_drv == '0) && (cap_drv == '0)));

    a_r9_mon_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mon_out);

endmodule

bind rcr_conv rcr_conv_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .ref_drv (ref_drv),
    .sns_drv (sns_drv),
    .cap_drv (cap_drv),
    .mon_out (mon_out),
    .busy    (busy),
    .ovf     (ovf),
    .irq     (irq)
);

// File: tb/rcr_conv_bench.sv
`timescale 1ns/1ps
module rcr_conv_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  osc = 2'b00;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        ch_sel = 1'b0;
    logic [15:0] preset = 16'h0;
    logic        irq_en = 1'b0;

    logic [1:0]  w_ref_drv, w_sns_drv, w_cap_drv;
    logic        w_mon_out, w_busy, w_ovf, w_irq;
    logic [15:0] w_result;
    logic [1:0]  n_ref_drv, n_sns_drv, n_cap_drv;
    logic        n_mon_out, n_busy, n_ovf, n_irq;
    logic [7:0]  n_result;

    always #2.5 clk = ~clk;

    rcr_conv u_rcr_conv (
        .clk(clk), .rst(rst), .osc_in(osc), .start(start), .stop(stop),
        .ch_sel(ch_sel), .preset(preset), .irq_en(irq_en),
        .ref_drv(w_ref_drv), .sns_drv(w_sns_drv), .cap_drv(w_cap_drv),
        .mon_out(w_mon_out), .busy(w_busy), .result(w_result),
        .ovf(w_ovf), .irq(w_irq)
    );

    rcr_conv #(.CNT_W(8)) u_rcr_conv_narrow (
        .clk(clk), .rst(rst), .osc_in(osc), .start(start), .stop(stop),
        .ch_sel(ch_sel), .preset(preset), .irq_en(irq_en),
        .ref_drv(n_ref_drv), .sns_drv(n_sns_drv), .cap_drv(n_cap_drv),
        .mon_out(n_mon_out), .busy(n_busy), .result(n_result),
        .ovf(n_ovf), .irq(n_irq)
    );

    int nchecks = 0;
    int nerr = 0;
    int cyc = 0;

    // oscillator model: period depends on which element of the channel is driven
    int pr [2];
    int ps [2];
    int ph [2];
    int kind_prev [2];
    bit noise_en = 1'b0;
    int act_ch = 0;

    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            int kind;
            int p;
            kind = w_sns_drv[c] ? 2 : (w_ref_drv[c] ? 1 : 0);
            p = (kind == 2) ? ps[c] : pr[c];
            if (kind == 0) begin
                ph[c] = 0;
                osc[c] = (noise_en && c != act_ch) ? 1'($urandom % 2) : 1'b0;
            end else if (kind != kind_prev[c]) begin
                ph[c] = 0;
                osc[c] = 1'b0;
            end else begin
                ph[c] = (ph[c] + 1) % p;
                osc[c] = (ph[c] >= p / 2);
            end
            kind_prev[c] = kind;
        end
    end

    // observation just after each active edge
    int  ref_cyc, sns_cyc, other_cyc, w_irq_cnt, n_irq_cnt, mon_err;
    int  cur_ch = 0;
    bit  prev_busy = 1'b0;
    logic [1:0] osc_prev = 2'b00;

    always @(posedge clk) begin
        #1;
        if (w_ref_drv[cur_ch]) ref_cyc++;
        if (w_sns_drv[cur_ch]) sns_cyc++;
        if (((w_ref_drv | w_sns_drv | w_cap_drv) & ~(2'b01 << cur_ch)) != 2'b00) other_cyc++;
        if (w_irq) w_irq_cnt++;
        if (n_irq) n_irq_cnt++;
        if (w_busy && prev_busy && (w_mon_out !== osc_prev[cur_ch])) mon_err++;
        osc_prev = osc;
        prev_busy = w_busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_len(input int n, input int r);
        return (n - 1) * r + r / 2 + 3;
    endfunction

    function automatic int sns_edges(input int t, input int s);
        if (t < 3 + s / 2) return 0;
        return (t - 3 - s / 2) / s + 1;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic clear_counts();
        ref_cyc = 0; sns_cyc = 0; other_cyc = 0;
        w_irq_cnt = 0; n_irq_cnt = 0; mon_err = 0;
    endtask

    task automatic run_conv(input int ch, input int n, input int r, input int s,
                            input bit ie, input bit poke);
        int k;
        int texp;
        int eexp;
        act_ch = ch; cur_ch = ch; pr[ch] = r; ps[ch] = s;
        repeat (4) @(negedge clk);
        clear_counts();
        start = 1'b1; ch_sel = ch[0]; preset = 16'(65536 - n); irq_en = ie;
        @(negedge clk);
        start = 1'b0; irq_en = ~ie;
        chk(n_ovf == 1'b0 && w_ovf == 1'b0, "R6", "ovf cleared by start", n_ovf, 0);
        chk(w_busy && w_ref_drv == (2'b01 << ch) && w_cap_drv == (2'b01 << ch)
            && w_sns_drv == 2'b00, "R2", "drives after start", w_ref_drv, 2'b01 << ch);
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1; ch_sel = ~ch[0]; preset = 16'hFF00;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (w_busy && k < 100000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        texp = ref_len(n, r);
        eexp = sns_edges(texp, s);
        chk(iabs(ref_cyc - texp) <= 1, poke ? "R7" : "R3", "reference phase cycles", ref_cyc, texp);
        chk(sns_cyc == ref_cyc, "R4", "sensor phase cycles", sns_cyc, ref_cyc);
        chk(iabs(int'(w_result) - eexp) <= 1, "R4", "result", w_result, eexp);
        chk(int'(n_result) == ((w_result > 255) ? 255 : int'(w_result)), "R6",
            "narrow saturated result", n_result, (w_result > 255) ? 255 : w_result);
        chk(n_ovf == (w_result >= 256), "R6", "narrow ovf", n_ovf, w_result >= 256);
        chk(w_irq_cnt == (ie ? 1 : 0) && n_irq_cnt == (ie ? 1 : 0), "R5",
            "irq pulses", w_irq_cnt, ie ? 1 : 0);
        chk(!w_busy && w_ref_drv == 0 && w_sns_drv == 0 && w_cap_drv == 0, "R5",
            "idle after completion", w_busy, 0);
        chk(other_cyc == 0, "R10", "other channel driven cycles", other_cyc, 0);
        chk(mon_err == 0, "R9", "monitor mismatches", mon_err, 0);
    endtask

    task automatic stop_test(input bit in_sns);
        logic [15:0] saved;
        int k;
        saved = w_result;
        act_ch = 1; cur_ch = 1; pr[1] = 10; ps[1] = 4;
        repeat (4) @(negedge clk);
        clear_counts();
        start = 1'b1; ch_sel = 1'b1; preset = 16'(65536 - 32); irq_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (in_sns) begin
            k = 0;
            while (w_sns_drv == 2'b00 && k < 10000) begin
                @(negedge clk);
                k++;
            end
            repeat (5) @(negedge clk);
        end else begin
            repeat (20) @(negedge clk);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!w_busy && w_ref_drv == 0 && w_sns_drv == 0 && w_cap_drv == 0, "R8",
            "aborted on next cycle", {w_busy, w_ref_drv, w_sns_drv}, 0);
        repeat (10) @(negedge clk);
        chk(w_irq_cnt == 0, "R8", "irq after stop", w_irq_cnt, 0);
        chk(w_result == saved, "R8", "result kept after stop", w_result, saved);
        chk(w_mon_out == 1'b0, "R9", "monitor idle", w_mon_out, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            nchecks++;
            nerr++;
            $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20140523));
        for (int c = 0; c < 2; c++) begin
            pr[c] = 8; ps[c] = 8; ph[c] = 0; kind_prev[c] = 0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(w_ref_drv == 0 && w_sns_drv == 0 && w_cap_drv == 0, "R1", "drives after reset", w_ref_drv, 0);
        chk(!w_busy && !w_irq && !w_mon_out, "R1", "busy irq mon after reset", {w_busy, w_irq, w_mon_out}, 0);
        chk(w_result == 0 && !w_ovf, "R1", "result ovf after reset", w_result, 0);

        // directed: single-edge preset, slow sensor, fast sensor with overflow
        run_conv(0, 1, 8, 2, 1'b1, 1'b0);
        run_conv(1, 40, 4, 20, 1'b1, 1'b0);
        run_conv(0, 64, 16, 2, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(n_ovf == 1'b1, "R6", "ovf sticky while idle", n_ovf, 1);
        run_conv(1, 20, 6, 6, 1'b0, 1'b0);
        // start while busy must be ignored
        run_conv(0, 30, 8, 4, 1'b1, 1'b1);
        stop_test(1'b0);
        stop_test(1'b1);

        // random mix with noise on the idle channel
        noise_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            int ch;
            int n;
            int r;
            int s;
            ch = int'($urandom % 2);
            n = 4 + int'($urandom % 37);
            r = 2 * (2 + int'($urandom % 9));
            s = 2 * (1 + int'($urandom % 10));
            run_conv(ch, n, r, s, 1'($urandom % 2), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule